// File: doc/BRIEF.md
# Shadow-Tag MSI Coherence Directory

This block is the parent side of an MSI coherence scheme for a small multicore with private L1 data caches and no shared second-level cache. It does not keep state for the whole address space. For each child core it holds a copy of that core's L1 tag and MSI state for every cache row. A line whose stored tag at its row does not match is treated as Invalid in that core.

A child asks to move a line up to S or M. The directory compares the request with every other core's state for that line. It sends a downgrade request to each core whose state conflicts and sets a waiting flag for that core. The flag clears when that core's downgrade response arrives. Once no conflict and no wait remain, the directory grants the request. If the requester held the line as Invalid, it first reads the line from a long-latency memory port and returns the data. Otherwise the response carries no data. On the grant, the requester's tag and new state are written into its shadow entry. A combinational lookup port reports the state of any line in any core.

All addresses on the ports are cache-line addresses: the byte address shifted right by the line-offset width (6 for 64-byte lines). The low `ROW_W` bits of a line address select the row and the remaining bits form the tag.

Top module: `shadow_dir`

## Requirements
- R1: After reset, every entry of every core reads as I, and `up_req_ready` is 1. The state encoding is I = 0, S = 1, M = 2.
- R2: `lk_st` returns the stored state of core `lk_core` at row `lk_line[ROW_W-1:0]` when the stored tag equals `lk_line[LINE_W-1:ROW_W]`, and returns I otherwise. A different line that maps to the same row reads as I.
- R3: Other cores that conflict with the request receive a downgrade request, one per cycle in ascending core order, carrying the requested line. The target is I when the request is for M, and S when the request is for S. A core is never asked twice while its waiting flag is set.
- R4: Two states conflict unless both are S or at least one is I; the requester's own state is never considered. An upgrade response is issued only when no other core conflicts and no waiting flag is set. A downgrade response from a core clears that core's flag.
- R5: When the requester's state for the line is I, one memory read of the line is issued, and the response has `up_rsp_has_data` = 1 with the returned data. Otherwise no memory read is issued, `up_rsp_has_data` = 0 and `up_rsp_data` is zero.
- R6: A grant writes the requester's tag and the granted state at the line's row. The grant response echoes the requester core, the line and the granted state.
- R7: A downgrade response sets the responding core's entry for the reported line to the reported state.
- R8: Only one request is handled at a time. `up_req_ready` is low from the cycle after acceptance until the cycle after the upgrade response. In any cycle at most one of ready, downgrade request, memory request and upgrade response is active.
- R9: Let the request be accepted at clock edge E. With no conflicts, the grant decision falls in the cycle after E. The response follows one cycle after the decision, or, when data is fetched, one cycle after the edge that samples `mem_rsp_valid`. Downgrade requests start in the cycle after E. After the last downgrade response is sampled, the grant decision comes in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req_valid | input | 1 | Upgrade request present |
| up_req_ready | output | 1 | Directory idle and accepting a request |
| up_req_core | input | CORE_W | Requesting core |
| up_req_line | input | LINE_W | Requested line address |
| up_req_st | input | 2 | Requested state (S or M) |
| dn_req_valid | output | 1 | Downgrade request to a child |
| dn_req_core | output | CORE_W | Core asked to downgrade |
| dn_req_line | output | LINE_W | Line to downgrade |
| dn_req_st | output | 2 | Target state of the downgrade |
| dn_rsp_valid | input | 1 | Downgrade response present |
| dn_rsp_core | input | CORE_W | Responding core |
| dn_rsp_line | input | LINE_W | Downgraded line |
| dn_rsp_st | input | 2 | State the child now holds |
| up_rsp_valid | output | 1 | Upgrade granted |
| up_rsp_core | output | CORE_W | Core that is granted |
| up_rsp_line | output | LINE_W | Granted line |
| up_rsp_st | output | 2 | Granted state |
| up_rsp_has_data | output | 1 | Response carries line data |
| up_rsp_data | output | DATA_W | Line data, zero when absent |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_line | output | LINE_W | Line to read |
| mem_rsp_valid | input | 1 | Memory read data present |
| mem_rsp_data | input | DATA_W | Memory read data |
| lk_core | input | CORE_W | Lookup core |
| lk_line | input | LINE_W | Lookup line address |
| lk_st | output | 2 | State of the line in that core |

## Verification
The lookup port is combinational, so the bench reads it after settling within the same half cycle. Each request is driven at a falling edge. The bench then counts falling edges. The downgrade requests are due at counts 1 to k, with one request for each conflicting core. Each is answered three cycles later. The grant decision is due at count 1, or at k+4 when downgrades were needed. The response is due one count after the decision, or the memory latency plus one count later when data is fetched. The bench checks the response latency against this figure for every request. It samples every output at falling edges, away from the rising edge where the design moves.

// File: rtl/shadow_dir_pkg.sv
package shadow_dir_pkg;

  localparam logic [1:0] ST_I = 2'd0;
  localparam logic [1:0] ST_S = 2'd1;
  localparam logic [1:0] ST_M = 2'd2;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_RESOLVE,
    PH_FETCH,
    PH_REPLY
  } phase_e;

  // True when a peer holding 'held' blocks a grant of 'want'.
  function automatic logic msi_clash(input logic [1:0] held, input logic [1:0] want);
    return (held != ST_I) && ((want == ST_M) || (held == ST_M));
  endfunction

  // State a peer must fall to before 'want' can be granted.
  function automatic logic [1:0] dn_target(input logic [1:0] want);
    return (want == ST_M) ? ST_I : ST_S;
  endfunction

endpackage

// File: rtl/shadow_dir_tbl.sv
module shadow_dir_tbl
  import shadow_dir_pkg::*;
#(
  parameter int ROW_W = 3,
  parameter int TAG_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] a_idx,
  input  logic [TAG_W-1:0] a_tag,
  output logic [1:0]       a_st,
  input  logic [ROW_W-1:0] b_idx,
  input  logic [TAG_W-1:0] b_tag,
  output logic [1:0]       b_st,
  input  logic             gw_en,
  input  logic [ROW_W-1:0] gw_idx,
  input  logic [TAG_W-1:0] gw_tag,
  input  logic [1:0]       gw_st,
  input  logic             dw_en,
  input  logic [ROW_W-1:0] dw_idx,
  input  logic [TAG_W-1:0] dw_tag,
  input  logic [1:0]       dw_st
);

  localparam int ROWS = 1 << ROW_W;

  logic [TAG_W-1:0] tag_q [ROWS];
  logic [1:0]       st_q  [ROWS];
  logic [1:0]       st_d  [ROWS];

  always_comb begin
    for (int r = 0; r < ROWS; r++) st_d[r] = st_q[r];
    if (dw_en && (tag_q[dw_idx] == dw_tag)) st_d[dw_idx] = dw_st;
    if (gw_en) st_d[gw_idx] = gw_st;   // grant wins a same-entry collision
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) st_q[r] <= ST_I;
    end else begin
      for (int r = 0; r < ROWS; r++) st_q[r] <= st_d[r];
    end
  end

  always_ff @(posedge clk) begin
    if (gw_en) tag_q[gw_idx] <= gw_tag;
  end

  assign a_st = (tag_q[a_idx] == a_tag) ? st_q[a_idx] : ST_I;
  assign b_st = (tag_q[b_idx] == b_tag) ? st_q[b_idx] : ST_I;

endmodule

// File: rtl/shadow_dir_ctrl.sv
module shadow_dir_ctrl
  import shadow_dir_pkg::*;
#(
  parameter int NCORE  = 3,
  parameter int CORE_W = 2,
  parameter int LINE_W = 16,
  parameter int DATA_W = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   up_req_valid,
  input  logic [CORE_W-1:0]      up_req_core,
  input  logic [LINE_W-1:0]      up_req_line,
  input  logic [1:0]             up_req_st,
  input  logic [NCORE-1:0][1:0]  held_st,
  input  logic                   dn_rsp_valid,
  input  logic [CORE_W-1:0]      dn_rsp_core,
  input  logic                   mem_rsp_valid,
  input  logic [DATA_W-1:0]      mem_rsp_data,
  output logic                   up_req_ready,
  output logic                   dn_req_valid,
  output logic [CORE_W-1:0]      dn_req_core,
  output logic                   mem_req_valid,
  output logic                   up_rsp_valid,
  output logic                   up_rsp_has_data,
  output logic [DATA_W-1:0]      up_rsp_data,
  output logic [CORE_W-1:0]      req_core_q,
  output logic [LINE_W-1:0]      req_line_q,
  output logic [1:0]             req_st_q,
  output logic                   grant_we,
  output logic [NCORE-1:0]       waiting
);

  phase_e             ph_q, ph_d;
  logic [NCORE-1:0]   wait_q, wait_d;
  logic [NCORE-1:0]   clash, pend;
  logic [CORE_W-1:0]  pick;
  logic [1:0]         own_st;
  logic               latch_en, need_en, need_d, need_q, data_en;
  logic [DATA_W-1:0]  data_q;

  always_comb begin
    clash  = '0;
    own_st = ST_I;
    for (int c = 0; c < NCORE; c++) begin
      if (CORE_W'(c) == req_core_q) own_st = held_st[c];
      else if (msi_clash(held_st[c], req_st_q)) clash[c] = 1'b1;
    end
    pend = clash & ~wait_q;
    pick = '0;
    for (int c = NCORE - 1; c >= 0; c--) begin
      if (pend[c]) pick = CORE_W'(c);
    end
  end

  always_comb begin
    ph_d          = ph_q;
    wait_d        = wait_q;
    latch_en      = 1'b0;
    need_en       = 1'b0;
    need_d        = need_q;
    data_en       = 1'b0;
    up_req_ready  = 1'b0;
    dn_req_valid  = 1'b0;
    mem_req_valid = 1'b0;
    up_rsp_valid  = 1'b0;
    grant_we      = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        up_req_ready = 1'b1;
        if (up_req_valid) begin
          latch_en = 1'b1;
          ph_d     = PH_RESOLVE;
        end
      end
      PH_RESOLVE: begin
        if (|pend) begin
          dn_req_valid = 1'b1;
          for (int c = 0; c < NCORE; c++)
            if (CORE_W'(c) == pick) wait_d[c] = 1'b1;
        end else if ((clash == '0) && (wait_q == '0)) begin
          need_en = 1'b1;
          need_d  = (own_st == ST_I);
          if (own_st == ST_I) begin
            mem_req_valid = 1'b1;
            ph_d          = PH_FETCH;
          end else begin
            ph_d = PH_REPLY;
          end
        end
      end
      PH_FETCH: begin
        if (mem_rsp_valid) begin
          data_en = 1'b1;
          ph_d    = PH_REPLY;
        end
      end
      PH_REPLY: begin
        up_rsp_valid = 1'b1;
        grant_we     = 1'b1;
        ph_d         = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
    if (dn_rsp_valid) begin
      for (int c = 0; c < NCORE; c++)
        if (CORE_W'(c) == dn_rsp_core) wait_d[c] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      wait_q <= '0;
    end else begin
      ph_q   <= ph_d;
      wait_q <= wait_d;
    end
  end

  always_ff @(posedge clk) begin
    if (latch_en) begin
      req_core_q <= up_req_core;
      req_line_q <= up_req_line;
      req_st_q   <= up_req_st;
    end
    if (need_en) need_q <= need_d;
    if (data_en) data_q <= mem_rsp_data;
  end

  assign dn_req_core     = pick;
  assign up_rsp_has_data = need_q;
  assign up_rsp_data     = need_q ? data_q : '0;
  assign waiting         = wait_q;

endmodule

// File: rtl/shadow_dir.sv
module shadow_dir
  import shadow_dir_pkg::*;
#(
  parameter int NCORE  = 3,
  parameter int ROW_W  = 3,
  parameter int LINE_W = 16,
  parameter int DATA_W = 64,
  localparam int CORE_W = (NCORE > 1) ? $clog2(NCORE) : 1,
  localparam int TAG_W  = LINE_W - ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req_valid,
  output logic              up_req_ready,
  input  logic [CORE_W-1:0] up_req_core,
  input  logic [LINE_W-1:0] up_req_line,
  input  logic [1:0]        up_req_st,
  output logic              dn_req_valid,
  output logic [CORE_W-1:0] dn_req_core,
  output logic [LINE_W-1:0] dn_req_line,
  output logic [1:0]        dn_req_st,
  input  logic              dn_rsp_valid,
  input  logic [CORE_W-1:0] dn_rsp_core,
  input  logic [LINE_W-1:0] dn_rsp_line,
  input  logic [1:0]        dn_rsp_st,
  output logic              up_rsp_valid,
  output logic [CORE_W-1:0] up_rsp_core,
  output logic [LINE_W-1:0] up_rsp_line,
  output logic [1:0]        up_rsp_st,
  output logic              up_rsp_has_data,
  output logic [DATA_W-1:0] up_rsp_data,
  output logic              mem_req_valid,
  output logic [LINE_W-1:0] mem_req_line,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic [CORE_W-1:0] lk_core,
  input  logic [LINE_W-1:0] lk_line,
  output logic [1:0]        lk_st
);

  logic [1:0]             rs_q;
  logic                   rst_loc_n;
  logic [NCORE-1:0][1:0]  held_vec;
  logic [NCORE-1:0][1:0]  lk_vec;
  logic [CORE_W-1:0]      req_core_q;
  logic [LINE_W-1:0]      req_line_q;
  logic [1:0]             req_st_q;
  logic                   grant_we;
  logic [NCORE-1:0]       waiting;

  // reset asserts at once, releases two edges after rst_n rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_loc_n = rs_q[1];

  shadow_dir_ctrl #(
    .NCORE(NCORE), .CORE_W(CORE_W), .LINE_W(LINE_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_loc_n),
    .up_req_valid(up_req_valid), .up_req_core(up_req_core),
    .up_req_line(up_req_line), .up_req_st(up_req_st),
    .held_st(held_vec),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_core(dn_rsp_core),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .up_req_ready(up_req_ready), .dn_req_valid(dn_req_valid),
    .dn_req_core(dn_req_core), .mem_req_valid(mem_req_valid),
    .up_rsp_valid(up_rsp_valid), .up_rsp_has_data(up_rsp_has_data),
    .up_rsp_data(up_rsp_data),
    .req_core_q(req_core_q), .req_line_q(req_line_q), .req_st_q(req_st_q),
    .grant_we(grant_we), .waiting(waiting)
  );

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    shadow_dir_tbl #(.ROW_W(ROW_W), .TAG_W(TAG_W)) u_tbl (
      .clk(clk), .rst_n(rst_loc_n),
      .a_idx(req_line_q[ROW_W-1:0]), .a_tag(req_line_q[LINE_W-1:ROW_W]),
      .a_st(held_vec[c]),
      .b_idx(lk_line[ROW_W-1:0]), .b_tag(lk_line[LINE_W-1:ROW_W]),
      .b_st(lk_vec[c]),
      .gw_en(grant_we && (req_core_q == CORE_W'(c))),
      .gw_idx(req_line_q[ROW_W-1:0]), .gw_tag(req_line_q[LINE_W-1:ROW_W]),
      .gw_st(req_st_q),
      .dw_en(dn_rsp_valid && (dn_rsp_core == CORE_W'(c))),
      .dw_idx(dn_rsp_line[ROW_W-1:0]), .dw_tag(dn_rsp_line[LINE_W-1:ROW_W]),
      .dw_st(dn_rsp_st)
    );
  end

  always_comb begin
    lk_st = ST_I;
    for (int c = 0; c < NCORE; c++)
      if (CORE_W'(c) == lk_core) lk_st = lk_vec[c];
  end

  assign dn_req_line  = req_line_q;
  assign dn_req_st    = dn_target(req_st_q);
  assign up_rsp_core  = req_core_q;
  assign up_rsp_line  = req_line_q;
  assign up_rsp_st    = req_st_q;
  assign mem_req_line = req_line_q;

endmodule

// File: rtl/shadow_dir_chk.sv
module shadow_dir_chk #(
  parameter int NCORE  = 3,
  parameter int CORE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_req_ready,
  input logic              dn_req_valid,
  input logic [CORE_W-1:0] dn_req_core,
  input logic [1:0]        dn_req_st,
  input logic              dn_rsp_valid,
  input logic [CORE_W-1:0] dn_rsp_core,
  input logic              up_rsp_valid,
  input logic              mem_req_valid,
  input logic [NCORE-1:0]  waiting
);

  assert_grant_no_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    up_rsp_valid |-> (waiting == '0));

  assert_rsp_clears_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dn_rsp_valid |=> !waiting[$past(dn_rsp_core)]);

  assert_req_sets_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid && !(dn_rsp_valid && (dn_rsp_core == dn_req_core)))
      |=> waiting[$past(dn_req_core)]);

  assert_dn_never_m_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid |-> (dn_req_st != 2'd2));

  assert_one_action_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({up_req_ready, dn_req_valid, mem_req_valid, up_rsp_valid}));

  assert_idle_after_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    up_rsp_valid |=> up_req_ready);

endmodule

bind shadow_dir shadow_dir_chk #(.NCORE(NCORE), .CORE_W(CORE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_req_ready(up_req_ready),
  .dn_req_valid(dn_req_valid), .dn_req_core(dn_req_core), .dn_req_st(dn_req_st),
  .dn_rsp_valid(dn_rsp_valid), .dn_rsp_core(dn_rsp_core),
  .up_rsp_valid(up_rsp_valid), .mem_req_valid(mem_req_valid),
  .waiting(waiting)
);

// File: tb/shadow_dir_tb.sv
`timescale 1ns/1ps
module shadow_dir_tb;
  localparam int NCORE = 3, ROW_W = 3, LINE_W = 16, DATA_W = 64, CORE_W = 2;
  localparam int ROWS = 8, MEM_LAT = 4, CHILD_LAT = 3;

  logic clk, rst_n;
  logic up_req_valid, up_req_ready;
  logic [CORE_W-1:0] up_req_core;
  logic [LINE_W-1:0] up_req_line;
  logic [1:0] up_req_st;
  logic dn_req_valid;
  logic [CORE_W-1:0] dn_req_core;
  logic [LINE_W-1:0] dn_req_line;
  logic [1:0] dn_req_st;
  logic dn_rsp_valid;
  logic [CORE_W-1:0] dn_rsp_core;
  logic [LINE_W-1:0] dn_rsp_line;
  logic [1:0] dn_rsp_st;
  logic up_rsp_valid;
  logic [CORE_W-1:0] up_rsp_core;
  logic [LINE_W-1:0] up_rsp_line;
  logic [1:0] up_rsp_st;
  logic up_rsp_has_data;
  logic [DATA_W-1:0] up_rsp_data;
  logic mem_req_valid;
  logic [LINE_W-1:0] mem_req_line;
  logic mem_rsp_valid;
  logic [DATA_W-1:0] mem_rsp_data;
  logic [CORE_W-1:0] lk_core;
  logic [LINE_W-1:0] lk_line;
  logic [1:0] lk_st;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  logic [LINE_W-ROW_W-1:0] rtag [NCORE][ROWS];
  logic [1:0]              rst8 [NCORE][ROWS];

  shadow_dir #(.NCORE(NCORE), .ROW_W(ROW_W), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_dut (.*);

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic logic [1:0] ref_st(int c, logic [LINE_W-1:0] l);
    if (rtag[c][l[ROW_W-1:0]] == l[LINE_W-1:ROW_W]) return rst8[c][l[ROW_W-1:0]];
    return 2'd0;
  endfunction

  function automatic bit conflicts(logic [1:0] held, logic [1:0] want);
    return (held != 2'd0) && (want == 2'd2 || held == 2'd2);
  endfunction

  function automatic logic [DATA_W-1:0] mem_data(logic [LINE_W-1:0] l);
    return {16'hD00D, l, ~l, l ^ 16'h5A5A};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic look(int c, logic [LINE_W-1:0] l, string req);
    lk_core = CORE_W'(c);
    lk_line = l;
    #1;
    chk(lk_st == ref_st(c, l), req, "lookup state", lk_st, ref_st(c, l));
  endtask

  task automatic do_upgrade(int core, logic [LINE_W-1:0] line, logic [1:0] want);
    int exp_dn[NCORE];
    int k = 0, seen = 0, g, exp_lat, mem_cd = -1;
    int child_cd[NCORE];
    bit need, done = 0;
    logic [1:0] dtgt;
    need = (ref_st(core, line) == 2'd0);
    dtgt = (want == 2'd2) ? 2'd0 : 2'd1;
    for (int c = 0; c < NCORE; c++) begin
      child_cd[c] = -1;
      exp_dn[c] = 0;
      if (c != core && conflicts(ref_st(c, line), want)) begin
        exp_dn[k] = c;
        k++;
      end
    end
    g = (k == 0) ? 1 : k + 4;
    exp_lat = need ? g + MEM_LAT + 1 : g + 1;
    @(negedge clk);
    chk(up_req_ready == 1'b1, "R8", "ready before request", up_req_ready, 1);
    up_req_valid = 1;
    up_req_core = CORE_W'(core);
    up_req_line = line;
    up_req_st = want;
    for (int cyc = 1; cyc <= 400 && !done; cyc++) begin
      @(negedge clk);
      up_req_valid = 0;
      dn_rsp_valid = 0;
      mem_rsp_valid = 0;
      if (cyc == 1) chk(up_req_ready == 1'b0, "R8", "busy after accept", up_req_ready, 0);
      for (int c = 0; c < NCORE; c++) begin
        if (child_cd[c] > 0) begin
          child_cd[c]--;
          if (child_cd[c] == 0) begin
            dn_rsp_valid = 1;
            dn_rsp_core = CORE_W'(c);
            dn_rsp_line = line;
            dn_rsp_st = dtgt;
            child_cd[c] = -1;
          end
        end
      end
      if (mem_cd > 0) begin
        mem_cd--;
        if (mem_cd == 0) begin
          mem_rsp_valid = 1;
          mem_rsp_data = mem_data(line);
          mem_cd = -1;
        end
      end
      if (dn_req_valid) begin
        chk(seen < k && int'(dn_req_core) == exp_dn[seen], "R3", "downgrade core order",
            dn_req_core, exp_dn[seen]);
        chk(dn_req_st == dtgt, "R3", "downgrade target", dn_req_st, dtgt);
        chk(dn_req_line == line, "R3", "downgrade line", dn_req_line, line);
        if (int'(dn_req_core) < NCORE) child_cd[dn_req_core] = CHILD_LAT;
        seen++;
      end
      if (mem_req_valid) begin
        chk(need, "R5", "memory read only when requester is I", 1, need);
        chk(mem_req_line == line, "R5", "memory read line", mem_req_line, line);
        mem_cd = MEM_LAT;
      end
      if (up_rsp_valid) begin
        chk(seen == k, "R4", "downgrades before grant", seen, k);
        chk(cyc == exp_lat, "R9", "response latency", cyc, exp_lat);
        chk(int'(up_rsp_core) == core && up_rsp_line == line && up_rsp_st == want, "R6",
            "response fields", {up_rsp_core, up_rsp_line, up_rsp_st}, {2'(core), line, want});
        chk(up_rsp_has_data == need, "R5", "data flag", up_rsp_has_data, need);
        chk(up_rsp_data == (need ? mem_data(line) : '0), "R5", "response data",
            up_rsp_data, need ? mem_data(line) : '0);
        done = 1;
      end
    end
    if (!done) chk(0, "R8", "no upgrade response", 0, 1);
    for (int i = 0; i < k; i++) rst8[exp_dn[i]][line[ROW_W-1:0]] = dtgt;
    rtag[core][line[ROW_W-1:0]] = line[LINE_W-1:ROW_W];
    rst8[core][line[ROW_W-1:0]] = want;
    @(negedge clk);
    look(core, line, "R6");
    for (int c = 0; c < NCORE; c++) if (c != core) look(c, line, "R7");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL R8 watchdog expired: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [LINE_W-1:0] la, lb;
    void'($urandom(32'd2024));
    for (int c = 0; c < NCORE; c++)
      for (int r = 0; r < ROWS; r++) begin
        rtag[c][r] = '0;
        rst8[c][r] = 2'd0;
      end
    rst_n = 0; up_req_valid = 0; up_req_core = 0; up_req_line = 0; up_req_st = 0;
    dn_rsp_valid = 0; dn_rsp_core = 0; dn_rsp_line = 0; dn_rsp_st = 0;
    mem_rsp_valid = 0; mem_rsp_data = 0; lk_core = 0; lk_line = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(up_req_ready == 1'b1, "R1", "ready after reset", up_req_ready, 1);
    for (int c = 0; c < NCORE; c++) begin
      look(c, 16'h0000, "R1");
      look(c, 16'h0025, "R1");
    end
    la = 16'h0025;          // tag 4, row 5
    lb = 16'h002D;          // tag 5, row 5
    do_upgrade(0, la, 2'd2);   // fetch, no conflict
    do_upgrade(1, la, 2'd1);   // core0 M -> S
    do_upgrade(2, la, 2'd2);   // cores 0 and 1 S -> I, in order
    do_upgrade(1, lb, 2'd1);   // same row, other tag: no conflict (R2)
    @(negedge clk);
    look(1, la, "R2");
    look(2, lb, "R2");
    do_upgrade(1, lb, 2'd2);   // S -> M, no data (R5)
    for (int n = 0; n < 80; n++) begin
      int core;
      logic [LINE_W-1:0] l;
      logic [1:0] cur, want;
      core = int'($urandom % NCORE);
      l = {13'($urandom % 3), 3'($urandom % 4)};
      cur = ref_st(core, l);
      if (cur == 2'd2) continue;
      want = (cur == 2'd1) ? 2'd2 : (($urandom % 2) ? 2'd2 : 2'd1);
      do_upgrade(core, l, want);
      if (n % 8 == 0) begin
        @(negedge clk);
        look(int'($urandom % NCORE), {13'($urandom % 3), 3'($urandom % 8)}, "R2");
      end
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule